// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides what a translated page may be used for. Once address translation has located a page entry, the evaluator takes that entry's protection fields, the segment's two key bits, the current privilege state, the page's no-execute and guarded markers, its storage key and two per-key authority mask words. It then computes the read, write and execute rights for the page.

Three independent sources each grant or withhold rights, and the result is their intersection. The first is a protection-code table qualified by the selected segment key. The second is the no-execute/guard check. The third is the per-key authority masks.

For the access being attempted (load, store or instruction fetch), the block also raises a grant line. When access is refused, it raises fault status flags that name which source or sources caused the refusal, in the form an exception unit records. The block is purely combinational and fits between a translation lookup and the exception logic in a load/store or fetch pipeline.

Top module: `page_perm_eval`

## Requirements
- R1: The active key is `key_user` when `user_mode` is 1 and `key_super` when `user_mode` is 0.
- R2: The protection code is `{pp_hi, pp_lo}` (3 bits, `pp_hi` as the most significant bit). With active key 0, the codes map as follows:
  - codes 0, 1 and 2 give read, write and execute;
  - codes 3 and 6 give read and execute;
  - codes 4, 5 and 7 give nothing.
- R3: With active key 1, the codes map as follows:
  - codes 1 and 3 give read and execute;
  - code 2 gives read, write and execute;
  - codes 0, 4, 5, 6 and 7 give nothing.
- R4: When `no_exec` or `guarded` is 1, execute is withheld. Read and write are not changed by these two inputs.
- R5: For storage key k, the data mask slot starts at bit b = 2*(2^KEY_W-1-k). When `mask_en` is 1, `data_mask[b+1]` set withholds write and `data_mask[b]` set withholds read. Other bits of the mask have no effect.
- R6: When both `mask_en` and `inst_mask_en` are 1, `inst_mask[b]` set withholds execute. With either enable at 0 it has no effect. With `mask_en` at 0, `data_mask` has no effect.
- R7: Each of `rights_r`, `rights_w` and `rights_x` is the AND of the three sources.
- R8: `acc_type` selects the required right: 0 is read, 1 is write, 2 is fetch, and 3 is treated as read. `grant` equals the selected right.
- R9: On a refused fetch, the fault flags are set as follows:
  - `flt_noexec` is set if the no-execute/guard source withheld execute;
  - otherwise `flt_prot` is set if the code table withheld execute;
  - independently, `flt_imask` is set if the instruction mask withheld execute.
- R10: On a refused read or write, the fault flags are set as follows:
  - `flt_prot` is set if the code table withheld the needed right;
  - `flt_store` is set for a write;
  - `flt_mask` is set if the data mask withheld the needed right.
- R11: While `grant` is 1, all five fault flags are 0. A fault flag of one access type never appears for the other type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pp_hi | input | 1 | High bit of the protection code |
| pp_lo | input | 2 | Two low bits of the protection code |
| key_user | input | 1 | Segment key used in user state |
| key_super | input | 1 | Segment key used in privileged state |
| user_mode | input | 1 | 1 when running in user (problem) state |
| no_exec | input | 1 | Page marked no-execute |
| guarded | input | 1 | Page marked guarded |
| page_key | input | KEY_W | Storage key of the page |
| data_mask | input | 2*2^KEY_W | Per-key load/store authority mask |
| inst_mask | input | 2*2^KEY_W | Per-key fetch authority mask |
| mask_en | input | 1 | Enables the authority masks |
| inst_mask_en | input | 1 | Additionally enables the fetch mask |
| acc_type | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| rights_r | output | 1 | Combined read right |
| rights_w | output | 1 | Combined write right |
| rights_x | output | 1 | Combined execute right |
| grant | output | 1 | Required right present |
| flt_noexec | output | 1 | Fetch refused by no-execute/guard |
| flt_prot | output | 1 | Refused by the protection code |
| flt_store | output | 1 | Refused access was a write |
| flt_mask | output | 1 | Data access refused by the data mask |
| flt_imask | output | 1 | Fetch refused by the instruction mask |

## Verification
The bench builds the block with the default KEY_W of 5, so each mask word is 64 bits wide and has 32 key slots. Random storage keys cover every slot position. Directed cases pin the two end slots (key 0 at the top bits and key 31 at bit 0) and show that a set bit in a neighbouring slot has no effect. Random masks and codes exercise both key tables, both enables, and the concurrent reporting of several fault sources on one refused access.

// File: rtl/page_perm_eval.sv
module page_perm_eval #(
  parameter int KEY_W = 5
) (
  input  logic                         pp_hi,
  input  logic [1:0]                   pp_lo,
  input  logic                         key_user,
  input  logic                         key_super,
  input  logic                         user_mode,
  input  logic                         no_exec,
  input  logic                         guarded,
  input  logic [KEY_W-1:0]             page_key,
  input  logic [(2<<KEY_W)-1:0]        data_mask,
  input  logic [(2<<KEY_W)-1:0]        inst_mask,
  input  logic                         mask_en,
  input  logic                         inst_mask_en,
  input  logic [1:0]                   acc_type,
  output logic                         rights_r,
  output logic                         rights_w,
  output logic                         rights_x,
  output logic                         grant,
  output logic                         flt_noexec,
  output logic                         flt_prot,
  output logic                         flt_store,
  output logic                         flt_mask,
  output logic                         flt_imask
);
  localparam int POS_W = KEY_W + 1;

  logic       act_key;
  logic [2:0] code;
  logic       pp_r, pp_w, pp_x;
  logic       gx_ok;
  logic [POS_W-1:0] slot_lo, slot_hi;
  logic       am_r, am_w, am_x;
  logic       is_w, is_x, deny;

  assign act_key = user_mode ? key_user : key_super;
  assign code    = {pp_hi, pp_lo};

  always_comb begin
    {pp_r, pp_w, pp_x} = 3'b000;
    if (!act_key) begin
      case (code)
        3'd0, 3'd1, 3'd2: {pp_r, pp_w, pp_x} = 3'b111;
        3'd3, 3'd6:       {pp_r, pp_w, pp_x} = 3'b101;
        default:          {pp_r, pp_w, pp_x} = 3'b000;
      endcase
    end else begin
      case (code)
        3'd1, 3'd3:       {pp_r, pp_w, pp_x} = 3'b101;
        3'd2:             {pp_r, pp_w, pp_x} = 3'b111;
        default:          {pp_r, pp_w, pp_x} = 3'b000;
      endcase
    end
  end

  assign gx_ok = !(no_exec || guarded);

  // slot of key k starts at 2*(2^KEY_W-1-k), i.e. the inverted key shifted left
  assign slot_lo = {~page_key, 1'b0};
  assign slot_hi = {~page_key, 1'b1};

  assign am_r = !(mask_en && data_mask[slot_lo]);
  assign am_w = !(mask_en && data_mask[slot_hi]);
  assign am_x = !(mask_en && inst_mask_en && inst_mask[slot_lo]);

  assign rights_r = pp_r && am_r;
  assign rights_w = pp_w && am_w;
  assign rights_x = pp_x && gx_ok && am_x;

  assign is_w  = (acc_type == 2'd1);
  assign is_x  = (acc_type == 2'd2);
  assign grant = is_x ? rights_x : (is_w ? rights_w : rights_r);
  assign deny  = !grant;

  assign flt_noexec = deny && is_x && !gx_ok;
  assign flt_prot   = deny && (is_x ? (gx_ok && !pp_x) : (is_w ? !pp_w : !pp_r));
  assign flt_imask  = deny && is_x && !am_x;
  assign flt_store  = deny && is_w;
  assign flt_mask   = deny && !is_x && (is_w ? !am_w : !am_r);

  always_comb begin
    if (!$isunknown({acc_type, grant, no_exec, guarded, mask_en})) begin
      // R11
      grant_quiet_chk: assert (!grant || !(flt_noexec || flt_prot || flt_store || flt_mask || flt_imask));
      // R4
      guard_blocks_x_chk: assert (gx_ok || !rights_x);
      // R9
      fetch_cause_chk: assert (!(is_x && !grant) || (flt_noexec || flt_prot || flt_imask));
      // R9
      fetch_excl_chk: assert (!(flt_noexec && flt_prot));
      // R6
      mask_off_chk: assert (mask_en || !(flt_mask || flt_imask));
      // R11
      type_split_chk: assert (is_x || !(flt_noexec || flt_imask));
      // R10
      store_flag_chk: assert (!flt_store || (is_w && !rights_w));
    end
  end
endmodule

// File: tb/page_perm_eval_tb.sv
module page_perm_eval_tb_top;
  localparam int KEY_W = 5;
  localparam int NK    = 1 << KEY_W;
  localparam int MW    = 2 * NK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic pp_hi; logic [1:0] pp_lo;
  logic key_user, key_super, user_mode, no_exec, guarded;
  logic [KEY_W-1:0] page_key;
  logic [MW-1:0] data_mask, inst_mask;
  logic mask_en, inst_mask_en;
  logic [1:0] acc_type;
  logic rights_r, rights_w, rights_x, grant;
  logic flt_noexec, flt_prot, flt_store, flt_mask, flt_imask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  page_perm_eval #(.KEY_W(KEY_W)) dut_i (
    .pp_hi(pp_hi), .pp_lo(pp_lo), .key_user(key_user), .key_super(key_super),
    .user_mode(user_mode), .no_exec(no_exec), .guarded(guarded),
    .page_key(page_key), .data_mask(data_mask), .inst_mask(inst_mask),
    .mask_en(mask_en), .inst_mask_en(inst_mask_en), .acc_type(acc_type),
    .rights_r(rights_r), .rights_w(rights_w), .rights_x(rights_x), .grant(grant),
    .flt_noexec(flt_noexec), .flt_prot(flt_prot), .flt_store(flt_store),
    .flt_mask(flt_mask), .flt_imask(flt_imask)
  );

  // expected {r,w,x} from the code table
  function automatic logic [2:0] table_rwx(input logic k, input int c);
    if (k == 1'b0) begin
      if (c <= 2) return 3'b111;
      if (c == 3 || c == 6) return 3'b101;
      return 3'b000;
    end
    if (c == 2) return 3'b111;
    if (c == 1 || c == 3) return 3'b101;
    return 3'b000;
  endfunction

  // expected {r,w,x,grant,noexec,prot,store,mask,imask}
  function automatic logic [8:0] model();
    logic k; int c; int b;
    logic [2:0] t; logic ok_g; logic mr, mw, mx;
    logic r, w, x, g, fn, fp, fs, fm, fi;
    k = user_mode ? key_user : key_super;
    c = int'({pp_hi, pp_lo});
    t = table_rwx(k, c);
    ok_g = !(no_exec | guarded);
    b = 2 * (NK - 1 - int'(page_key));
    mr = !(mask_en && data_mask[b]);
    mw = !(mask_en && data_mask[b+1]);
    mx = !(mask_en && inst_mask_en && inst_mask[b]);
    r = t[2] & mr; w = t[1] & mw; x = t[0] & ok_g & mx;
    fn = 0; fp = 0; fs = 0; fm = 0; fi = 0;
    if (acc_type == 2'd2) begin
      g = x;
      if (!g) begin
        if (!ok_g) fn = 1; else if (!t[0]) fp = 1;
        fi = !mx;
      end
    end else if (acc_type == 2'd1) begin
      g = w;
      if (!g) begin fp = !t[1]; fs = 1; fm = !mw; end
    end else begin
      g = r;
      if (!g) begin fp = !t[2]; fm = !mr; end
    end
    return {r, w, x, g, fn, fp, fs, fm, fi};
  endfunction

  function automatic logic [8:0] got();
    return {rights_r, rights_w, rights_x, grant, flt_noexec, flt_prot, flt_store, flt_mask, flt_imask};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    pp_hi = 0; pp_lo = 0; key_user = 0; key_super = 0; user_mode = 0;
    no_exec = 0; guarded = 0; page_key = '0; data_mask = '0; inst_mask = '0;
    mask_en = 0; inst_mask_en = 0; acc_type = 0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    clear_in();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle state", got(), 9'b111_1_00000);

    // R1: user key=1 code 0 -> nothing; privileged key 0 -> all
    user_mode = 1; key_user = 1; key_super = 0; settle();
    check("R1 user key", got(), 9'b000_0_01000);
    user_mode = 0; settle();
    check("R1 super key", got(), 9'b111_1_00000);

    // R3: key 1, code 2 -> rwx; code 6 -> none
    key_super = 1; pp_lo = 2'd2; settle();
    check("R3 code2", got(), 9'b111_1_00000);
    pp_hi = 1; settle();
    check("R3 code6", got(), model());

    // R4: guarded removes x only
    pp_hi = 0; pp_lo = 0; key_super = 0; guarded = 1; acc_type = 2; settle();
    check("R4 guard fetch", got(), 9'b110_0_10000);
    acc_type = 1; settle();
    check("R4 guard write", got(), 9'b110_1_00000);
    guarded = 0;

    // R5: key 31 slot at bit 0/1, key 0 at top
    mask_en = 1; page_key = 5'd31; data_mask = MW'(2'b10); acc_type = 1; settle();
    check("R5 key31 write", got(), 9'b101_0_00110);
    page_key = 5'd30; settle();
    check("R5 neighbour slot", got(), 9'b111_1_00000);
    page_key = 5'd0; data_mask = '0; data_mask[MW-2] = 1'b1; acc_type = 0; settle();
    check("R5 key0 read", got(), 9'b011_0_00010);
    acc_type = 3; settle();
    check("R8 type3 as read", got(), 9'b011_0_00010);

    // R6: instruction mask needs both enables
    data_mask = '0; inst_mask = '0; inst_mask[MW-2] = 1'b1; acc_type = 2; settle();
    check("R6 imask off", got(), 9'b111_1_00000);
    inst_mask_en = 1; settle();
    check("R6 imask on", got(), 9'b110_0_00001);
    mask_en = 0; settle();
    check("R6 master off", got(), 9'b111_1_00000);

    // R9: code denies fetch plus imask
    mask_en = 1; pp_lo = 2'd0; pp_hi = 1; settle();
    check("R9 prot+imask", got(), 9'b000_0_01001);
    no_exec = 1; settle();
    check("R9 noexec wins", got(), 9'b000_0_10001);
    no_exec = 0;

    // R10: store on read-only with mask
    pp_hi = 0; pp_lo = 2'd3; inst_mask = '0; data_mask[MW-1] = 1'b1; acc_type = 1; settle();
    check("R10 store flags", got(), 9'b101_0_01110);

    for (int i = 0; i < 3000; i++) begin
      pp_hi = 1'($urandom); pp_lo = 2'($urandom);
      key_user = 1'($urandom); key_super = 1'($urandom); user_mode = 1'($urandom);
      no_exec = ($urandom % 4) == 0; guarded = ($urandom % 4) == 0;
      page_key = KEY_W'($urandom);
      data_mask = {$urandom, $urandom}; inst_mask = {$urandom, $urandom};
      mask_en = 1'($urandom); inst_mask_en = 1'($urandom); acc_type = 2'($urandom);
      settle();
      check("R1 R2 R3 R4 R5 R6 R7 rights", {got()[8:6], 6'd0}, {model()[8:6], 6'd0});
      check("R8 grant", {3'd0, got()[5], 5'd0}, {3'd0, model()[5], 5'd0});
      check("R9 R10 R11 flags", {4'd0, got()[4:0]}, {4'd0, model()[4:0]});
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule